// File: doc/BRIEF.md
# Beam-Position Display Interrupt Unit

This block holds four programmable display interrupts, each armed to fire when the raster reaches a chosen position. Every interrupt owns a register with a vertical line compare, a horizontal compare, an enable mask and a sticky status flag. The register is seen on a 16-bit bus as two words: a high word with status, mask and line compare, and a low word with the horizontal compare. The timing generator sends the running half-line count, a strobe for each half-line advance, and the half-line length in samples. The block drives one combined interrupt request.

The horizontal position is resolved only to half-line granularity. A horizontal compare larger than the half-line length selects the second half of the line (odd half-line count). Any other value selects the first half (even count). A display control register sits beside the interrupts. Its fields are stored for the rest of the display pipe. It also carries a self-clearing command bit that wipes all four interrupt registers.

Top module: `beam_irq_unit`

## Requirements
- R1: After reset, interrupt 0 holds horizontal compare 430, line compare 263, mask 1 and status 0. Interrupt 1 holds horizontal 1, line 1, mask 1 and status 0. Interrupts 2 and 3 are all zero. The control word reads 0x0001, and `irq` is 0.
- R2: On a cycle with `hl_step` high, interrupt i sets its status when two things hold: (`hl_count`/2)+1 equals its line compare, and `hl_count` bit 0 equals 1 if its horizontal compare exceeds `hl_len`, or 0 otherwise. The compare uses the register values held before that cycle's write. The new status is readable in the next cycle.
- R3: No status is set on a half-line whose parity does not match the selected half, nor in a cycle where `hl_step` is low.
- R4: `irq` is high exactly when some interrupt has both status and mask set. It follows each register change one cycle after the clock edge that makes the change.
- R5: Register addresses: the high word of interrupt i is at address 8+2i, with line compare in bits 9:0, mask in bit 12 and status in bit 15. The low word is at 9+2i, with horizontal compare in bits 10:0. A write replaces the fields of the addressed word. All other bits read 0.
- R6: Writing 0 to a status bit clears it. If a compare match sets the status in the same cycle as a write clearing it, the status stays set.
- R7: A write to address 0 with bit 1 set zeroes every field of all four interrupt registers, overriding any write or match in that cycle. `irq` is low in the next cycle, and bit 1 reads back 0.
- R8: The control word at address 0 stores only these bits: enable (bit 0), progressive (bit 2), stereo (bit 3), latch enables (bits 4 and 5) and format (bits 9:8). All other bits, including bit 1, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hl_step | input | 1 | Half-line advance strobe from the timing generator |
| hl_count | input | 11 | Half-line count of the current frame (0-based) |
| hl_len | input | 10 | Half-line length in samples |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | Combined display interrupt request |

## Verification
Every register change, whether from a write, a compare match or the clear command, takes effect at the clock edge where its stimulus is sampled. So the status, the read word and `irq` are all due one cycle later, and `rd_data` is valid in the same cycle as the read address. The bench drives on the falling edge, lets one rising edge pass, and samples on the next falling edge, so each result is read exactly one edge after its cause. A behavioural reference, updated on the same rising edge, gives the expected read word and `irq` for every cycle. Directed reads check the same-cycle orderings: set against clear, and clear command against match.

// File: rtl/beam_irq_pkg.sv
`timescale 1ns/1ps
package beam_irq_pkg;

  localparam int DATA_W   = 16;
  localparam int ST_BIT   = 15;  // status position in the high word
  localparam int MSK_BIT  = 12;  // mask position in the high word
  localparam int CLR_BIT  = 1;   // self-clearing wipe command in the control word

  typedef struct packed {
    logic [1:0] fmt;
    logic       latch1;
    logic       latch0;
    logic       stereo;
    logic       progressive;
    logic       enable;
  } disp_ctrl_t;

  // Full line number (1-based) of a half-line count.
  function automatic logic [31:0] line_of(input logic [31:0] hl);
    return (hl >> 1) + 32'd1;
  endfunction

  // A horizontal compare past the half-line length selects the odd half.
  function automatic logic wants_odd_half(input logic [31:0] hcmp, input logic [31:0] len);
    return hcmp > len;
  endfunction

  function automatic int rst_hcmp(input int idx);
    case (idx)
      0: return 430;
      1: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int rst_vcmp(input int idx);
    case (idx)
      0: return 263;
      1: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int rst_mask(input int idx);
    return (idx < 2) ? 1 : 0;
  endfunction

endpackage

// File: rtl/beam_irq_ctrl.sv
`timescale 1ns/1ps
module beam_irq_ctrl
  import beam_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_word,
  output logic              clear_all
);

  disp_ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q        <= '0;
      ctrl_q.enable <= 1'b1;
    end else if (wr) begin
      ctrl_q.enable      <= wr_data[0];
      ctrl_q.progressive <= wr_data[2];
      ctrl_q.stereo      <= wr_data[3];
      ctrl_q.latch0      <= wr_data[4];
      ctrl_q.latch1      <= wr_data[5];
      ctrl_q.fmt         <= wr_data[9:8];
    end
  end

  // The wipe command acts in its write cycle and is never stored.
  assign clear_all = wr && wr_data[CLR_BIT];

  always_comb begin
    ctrl_word      = '0;
    ctrl_word[0]   = ctrl_q.enable;
    ctrl_word[2]   = ctrl_q.progressive;
    ctrl_word[3]   = ctrl_q.stereo;
    ctrl_word[4]   = ctrl_q.latch0;
    ctrl_word[5]   = ctrl_q.latch1;
    ctrl_word[9:8] = ctrl_q.fmt;
  end

  // R8
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (ctrl_word[0] == $past(wr_data[0])) && (ctrl_word[9:8] == $past(wr_data[9:8])));

endmodule

// File: rtl/beam_irq_slot.sv
`timescale 1ns/1ps
module beam_irq_slot
  import beam_irq_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int LEN_W   = 10,
  parameter int VCT_W   = 10,
  parameter int HCT_W   = 11,
  parameter int DEF_HCT = 0,
  parameter int DEF_VCT = 0,
  parameter int DEF_MSK = 0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hl_step,
  input  logic [CNT_W-1:0]  hl_count,
  input  logic [LEN_W-1:0]  hl_len,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clear_all,
  output logic              status,
  output logic              mask,
  output logic              hit,
  output logic [DATA_W-1:0] hi_word,
  output logic [DATA_W-1:0] lo_word
);

  localparam logic [HCT_W-1:0] HCT_RST = HCT_W'(DEF_HCT);
  localparam logic [VCT_W-1:0] VCT_RST = VCT_W'(DEF_VCT);
  localparam logic             MSK_RST = (DEF_MSK != 0);

  logic [VCT_W-1:0] vcmp_q;
  logic [HCT_W-1:0] hcmp_q;
  logic             mask_q;
  logic             status_q;
  logic             line_eq;
  logic             half_eq;

  always_comb begin
    line_eq = (line_of(32'(hl_count)) == 32'(vcmp_q));
    half_eq = (hl_count[0] == wants_odd_half(32'(hcmp_q), 32'(hl_len)));
    hit     = hl_step && line_eq && half_eq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcmp_q   <= VCT_RST;
      hcmp_q   <= HCT_RST;
      mask_q   <= MSK_RST;
      status_q <= 1'b0;
    end else if (clear_all) begin
      vcmp_q   <= '0;
      hcmp_q   <= '0;
      mask_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (wr_hi) begin
        vcmp_q   <= wr_data[VCT_W-1:0];
        mask_q   <= wr_data[MSK_BIT];
        status_q <= wr_data[ST_BIT];
      end
      if (wr_lo) hcmp_q <= wr_data[HCT_W-1:0];
      if (hit)   status_q <= 1'b1;
    end
  end

  assign status = status_q;
  assign mask   = mask_q;

  always_comb begin
    hi_word                 = '0;
    hi_word[VCT_W-1:0]      = vcmp_q;
    hi_word[MSK_BIT]        = mask_q;
    hi_word[ST_BIT]         = status_q;
    lo_word                 = '0;
    lo_word[HCT_W-1:0]      = hcmp_q;
  end

  // R2
  match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clear_all) |=> status);

  // R3
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hl_step && !wr_hi && !clear_all) |=> $stable(status));

  // R6
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_data[ST_BIT] && !hit && !clear_all) |=> !status);

  // R7
  wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (hi_word == '0) && (lo_word == '0));

endmodule

// File: rtl/beam_irq_merge.sv
`timescale 1ns/1ps
module beam_irq_merge #(
  parameter int N_SLOT = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SLOT-1:0] status_v,
  input  logic [N_SLOT-1:0] mask_v,
  output logic              irq
);

  logic [N_SLOT-1:0] live_v;

  always_comb begin
    live_v = status_v & mask_v;
    irq    = |live_v;
  end

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(status_v) && $stable(mask_v)) |-> $stable(irq));

endmodule

// File: rtl/beam_irq_unit.sv
`timescale 1ns/1ps
module beam_irq_unit
  import beam_irq_pkg::*;
#(
  parameter int N_SLOT    = 4,
  parameter int CNT_W     = 11,
  parameter int LEN_W     = 10,
  parameter int VCT_W     = 10,
  parameter int HCT_W     = 11,
  parameter int ADDR_W    = 4,
  parameter int SLOT_BASE = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hl_step,
  input  logic [CNT_W-1:0]  hl_count,
  input  logic [LEN_W-1:0]  hl_len,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  logic                ctrl_wr;
  logic                clear_all;
  logic [DATA_W-1:0]   ctrl_word;
  logic [N_SLOT-1:0]   wr_hi_v;
  logic [N_SLOT-1:0]   wr_lo_v;
  logic [N_SLOT-1:0]   status_v;
  logic [N_SLOT-1:0]   mask_v;
  logic [N_SLOT-1:0]   hit_v;
  logic [DATA_W-1:0]   hi_words [N_SLOT];
  logic [DATA_W-1:0]   lo_words [N_SLOT];

  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);

  beam_irq_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (ctrl_wr),
    .wr_data   (wr_data),
    .ctrl_word (ctrl_word),
    .clear_all (clear_all)
  );

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(SLOT_BASE + 2 * g);
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(SLOT_BASE + 2 * g + 1);

    assign wr_hi_v[g] = wr_en && (wr_addr == HI_ADDR);
    assign wr_lo_v[g] = wr_en && (wr_addr == LO_ADDR);

    beam_irq_slot #(
      .CNT_W   (CNT_W),
      .LEN_W   (LEN_W),
      .VCT_W   (VCT_W),
      .HCT_W   (HCT_W),
      .DEF_HCT (rst_hcmp(g)),
      .DEF_VCT (rst_vcmp(g)),
      .DEF_MSK (rst_mask(g))
    ) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .hl_step   (hl_step),
      .hl_count  (hl_count),
      .hl_len    (hl_len),
      .wr_hi     (wr_hi_v[g]),
      .wr_lo     (wr_lo_v[g]),
      .wr_data   (wr_data),
      .clear_all (clear_all),
      .status    (status_v[g]),
      .mask      (mask_v[g]),
      .hit       (hit_v[g]),
      .hi_word   (hi_words[g]),
      .lo_word   (lo_words[g])
    );
  end

  beam_irq_merge #(.N_SLOT(N_SLOT)) merge_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_v (status_v),
    .mask_v   (mask_v),
    .irq      (irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_ADDR) rd_data = ctrl_word;
    for (int i = 0; i < N_SLOT; i++) begin
      if (rd_addr == ADDR_W'(SLOT_BASE + 2 * i))     rd_data = hi_words[i];
      if (rd_addr == ADDR_W'(SLOT_BASE + 2 * i + 1)) rd_data = lo_words[i];
    end
  end

  // R7
  wipe_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> !irq);

  // R2
  hit_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit_v & mask_v & ~wr_hi_v) && !clear_all) |=> irq);

endmodule

// File: tb/beam_irq_unit_tb.sv
`timescale 1ns/1ps
module beam_irq_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hl_step = 1'b0;
  logic [10:0] hl_count = '0;
  logic [9:0]  hl_len = 10'd429;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  logic [3:0] sweep = '0;
  logic [31:0] lfsr = 32'h1BEE_F00D;

  always #2.5 clk = ~clk;

  beam_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .hl_step(hl_step), .hl_count(hl_count), .hl_len(hl_len),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  // Behavioural reference
  int m_hct [4] = '{430, 1, 0, 0};
  int m_vct [4] = '{263, 1, 0, 0};
  int m_msk [4] = '{1, 1, 0, 0};
  int m_st  [4] = '{0, 0, 0, 0};
  int m_ctl = 1;

  always @(posedge clk) begin
    bit hitm [4];
    bit wipe;
    if (!rst_n) begin
      m_hct = '{430, 1, 0, 0}; m_vct = '{263, 1, 0, 0};
      m_msk = '{1, 1, 0, 0};   m_st  = '{0, 0, 0, 0};
      m_ctl = 1;
    end else begin
      for (int i = 0; i < 4; i++)
        hitm[i] = hl_step && ((int'(hl_count) / 2 + 1) == m_vct[i]) &&
                  ((int'(hl_count) % 2) == ((m_hct[i] > int'(hl_len)) ? 1 : 0));
      wipe = wr_en && (wr_addr == 0) && wr_data[1];
      if (wr_en && wr_addr == 0) m_ctl = int'(wr_data & 16'h033D);
      for (int i = 0; i < 4; i++) begin
        if (wr_en && int'(wr_addr) == 8 + 2 * i) begin
          m_vct[i] = int'(wr_data[9:0]);
          m_msk[i] = int'(wr_data[12]);
          m_st[i]  = int'(wr_data[15]);
        end
        if (wr_en && int'(wr_addr) == 9 + 2 * i) m_hct[i] = int'(wr_data[10:0]);
        if (hitm[i]) m_st[i] = 1;
      end
      if (wipe)
        for (int i = 0; i < 4; i++) begin
          m_hct[i] = 0; m_vct[i] = 0; m_msk[i] = 0; m_st[i] = 0;
        end
    end
  end

  function automatic int model_rd(input int a);
    if (a == 0) return m_ctl;
    for (int i = 0; i < 4; i++) begin
      if (a == 8 + 2 * i) return (m_st[i] << 15) | (m_msk[i] << 12) | m_vct[i];
      if (a == 9 + 2 * i) return m_hct[i];
    end
    return 0;
  endfunction

  function automatic int model_irq();
    int r = 0;
    for (int i = 0; i < 4; i++) r |= (m_st[i] & m_msk[i]);
    return r;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // One clock: drive after a falling edge, sample on the next falling edge.
  task automatic tick(input logic we, input int a, input int d, input logic st, input int c);
    wr_en = we; wr_addr = 4'(a); wr_data = 16'(d); hl_step = st; hl_count = 11'(c);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; hl_step = 1'b0;
    rd_addr = sweep; sweep = sweep + 4'd1;
    #0.5;
    check(cur_req, "irq vs model", int'(irq), model_irq());
    check(cur_req, $sformatf("rd[%0d] vs model", rd_addr), int'(rd_data), model_rd(int'(rd_addr)));
  endtask

  task automatic chk_rd(input int a, input int exp, input string req);
    rd_addr = 4'(a);
    #0.1;
    check(req, $sformatf("rd[%0d]", a), int'(rd_data), exp);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    chk_rd(0, 16'h0001, "R1");
    chk_rd(8, 16'h1107, "R1");
    chk_rd(9, 430, "R1");
    chk_rd(10, 16'h1001, "R1");
    chk_rd(11, 1, "R1");
    for (int a = 12; a < 16; a++) chk_rd(a, 0, "R1");
    check("R1", "irq", int'(irq), 0);
    for (int k = 0; k < 16; k++) tick(0, 0, 0, 0, 0);

    // R5 field writes
    cur_req = "R5";
    tick(1, 12, 16'h1005, 0, 0);
    tick(1, 13, 100, 0, 0);
    tick(1, 14, 16'h0005, 0, 0);
    tick(1, 15, 500, 0, 0);
    tick(1, 10, 16'h0001, 0, 0);
    chk_rd(12, 16'h1005, "R5");
    chk_rd(15, 16'h01F4, "R5");
    chk_rd(10, 16'h0001, "R5");

    // R2 / R4: sweep half-lines; slot 1 hits at count 0 but is unmasked
    cur_req = "R2";
    for (int c = 0; c < 8; c++) tick(0, 0, 0, 1, c);
    chk_rd(10, 16'h8001, "R2");
    check("R4", "irq with unmasked status only", int'(irq), 0);
    tick(0, 0, 0, 1, 8);
    check("R2", "irq after even-half match", int'(irq), 1);
    chk_rd(12, 16'h9005, "R2");
    chk_rd(14, 16'h0005, "R3");
    tick(0, 0, 0, 1, 9);
    chk_rd(14, 16'h8005, "R3");

    // R6 clear by write, R3 no set without strobe
    cur_req = "R6";
    tick(1, 12, 16'h1005, 0, 0);
    check("R6", "irq after status clear", int'(irq), 0);
    cur_req = "R3";
    tick(0, 0, 0, 0, 8);
    chk_rd(12, 16'h1005, "R3");
    cur_req = "R6";
    tick(1, 12, 16'h1005, 1, 8);
    chk_rd(12, 16'h9005, "R6");
    check("R6", "irq when set beats clear", int'(irq), 1);

    // R7 wipe command (also a match in the same cycle)
    cur_req = "R7";
    tick(1, 0, 16'h0313, 1, 8);
    check("R7", "irq after wipe", int'(irq), 0);
    chk_rd(0, 16'h0311, "R7");
    for (int a = 8; a < 16; a++) chk_rd(a, 0, "R7");

    // R8 stored control fields only
    cur_req = "R8";
    tick(1, 0, 16'hFCFC, 0, 0);
    chk_rd(0, 16'h003C, "R8");
    tick(1, 0, 16'h0300, 0, 0);
    chk_rd(0, 16'h0300, "R8");

    // Mixed traffic compared against the model every clock
    cur_req = "R2";
    for (int k = 0; k < 600; k++) begin
      int a, d;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      a = int'(lfsr[3:0]);
      d = int'(lfsr[31:16]);
      if (a == 0 && lfsr[8:6] != 3'd0) d = d & ~2;
      if (a >= 8 && a[0] == 1'b0) d = (d & 16'hF000) | int'(lfsr[7:4]) + 1;
      if (a >= 8 && a[0] == 1'b1) d = lfsr[9] ? 600 : int'(lfsr[7:0]);
      hl_len = 10'd429;
      tick(lfsr[10] & lfsr[11], a, d, lfsr[12], int'(lfsr[20:16]));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule